// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarm

This block keeps wall-clock time as a running count of seconds. A one-cycle tick-enable pulse, produced elsewhere once per second, advances the counter by one. Software controls the block through a small synchronous register port that carries an address, a write strobe, write data and combinational read data. Through that port it can read the count, set it to a new value, and program a match value that raises an alarm when the count reaches it.

The alarm sets a sticky raw flag. A one-bit mask gates the raw flag onto a level interrupt line. Software drops the flag by writing anything to the clear register. The counter and the comparison both wrap modulo 2^32. A control register reads back as always enabled. Eight identification bytes occupy the last eight words of the 4 KB window.

Register decode uses the word index `bus_addr[11:2]`. Address bits [1:0] are ignored.

Top module: `secs_rtc`

## Requirements
- R1: While `rst` is high at a clock edge, the count, match, load and mask registers and the raw flag clear to zero. After that edge, `irq_o` is 0 and reads of offsets 0x00, 0x04, 0x10 and 0x14 return 0.
- R2: At each clock edge where `tick_i` is 1 and no load write happens, the count (read at 0x00) increases by exactly one, wrapping from 0xFFFFFFFF to 0. With `tick_i` low, the count holds.
- R3: A write to offset 0x08 makes the count equal to the written value at the next edge. This holds even if `tick_i` is high in the same cycle. Reading 0x08 returns the last value written there.
- R4: Offset 0x04 holds a 32-bit match value that reads back exactly as written.
- R5: The raw flag (bit 0 of offset 0x14) is set at an edge where `tick_i` is 1, no load write happens, and count+1 (mod 2^32) equals the match value. Once set, it stays set until cleared. It works across the wrap point.
- R6: Any write to offset 0x1C clears the raw flag, whatever the data. If the flag is set in that same cycle, the set wins and the flag stays 1.
- R7: Offset 0x10 stores only bit 0 (the mask) and reads with bits 31:1 zero. `irq_o` and bit 0 of offset 0x18 both equal raw AND mask.
- R8: Offset 0x0C always reads 1, and writes to it have no effect.
- R9: Offsets 0xFE0, 0xFE4, ..., 0xFFC read one byte each in bits 7:0, with the upper bits zero. The bytes, in rising address order, are 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Reads of unmapped offsets return 0. Writes to the read-only count offset 0x00 or to unmapped offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per second that advances the count |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt: raw flag AND mask |

## Verification
The alarm path is exercised with three patterns:
- A match value a few ticks ahead of a freshly loaded count. This separates firing on the incremented count from firing on the held count, because the flag must stay low one tick before the match and rise exactly on it.
- A match value below the current count. This is reached by loading a count just under the wrap point, and it shows whether the comparison wraps.
- A tick that coincides with a clear-register write. This shows which of set and clear takes priority.

Mask on and off, with the flag both up and down, separate the masked view from the raw view. Writes to read-only and unmapped offsets, followed by readback of the count, show that those writes are ignored.

// File: rtl/secs_rtc_pkg.sv
`timescale 1ns/1ps
package secs_rtc_pkg;

   // Word indices (byte offset >> 2) of the mapped registers
   localparam int unsigned WIDX_COUNT = 0;
   localparam int unsigned WIDX_MATCH = 1;
   localparam int unsigned WIDX_LOAD  = 2;
   localparam int unsigned WIDX_CTRL  = 3;
   localparam int unsigned WIDX_MASK  = 4;
   localparam int unsigned WIDX_RAW   = 5;
   localparam int unsigned WIDX_MSKD  = 6;
   localparam int unsigned WIDX_CLR   = 7;

   localparam int unsigned ID_WORDS = 8;

   // Identification byte for position i of the ID block
   function automatic logic [7:0] id_byte(input int unsigned i);
      case (i)
         0: return 8'h31;
         1: return 8'h10;
         2: return 8'h14;
         3: return 8'h00;
         4: return 8'h0D;
         5: return 8'hF0;
         6: return 8'h05;
         default: return 8'hB1;
      endcase
   endfunction

   // Write strobes produced by the decoder
   typedef struct packed {
      logic load;
      logic match;
      logic mask;
      logic clr;
   } wr_sel_t;

endpackage

// File: rtl/secs_rtc_counter.sv
`timescale 1ns/1ps
module secs_rtc_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_i,
   input  logic             ld_we,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_inc,
   output logic [CNT_W-1:0] ld_q
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // One adder, shared with the alarm comparison
   assign cnt_inc = cnt_q + ONE;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         ld_q  <= '0;
      end else begin
         if (ld_we) begin
            cnt_q <= ld_val;
            ld_q  <= ld_val;
         end else if (tick_i) begin
            cnt_q <= cnt_inc;
         end
      end
   end

endmodule

// File: rtl/secs_rtc_alarm.sv
`timescale 1ns/1ps
module secs_rtc_alarm #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_i,
   input  logic             ld_we,
   input  logic [CNT_W-1:0] cnt_inc,
   input  logic             match_we,
   input  logic [CNT_W-1:0] match_wd,
   input  logic             mask_we,
   input  logic             mask_wd,
   input  logic             clr_we,
   output logic [CNT_W-1:0] match_q,
   output logic             mask_q,
   output logic             raw_q,
   output logic             irq_o
);

   logic hit;

   // Fires only on a real tick step, never on a load
   assign hit = tick_i && !ld_we && (cnt_inc == match_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         match_q <= '0;
         mask_q  <= 1'b0;
         raw_q   <= 1'b0;
      end else begin
         if (match_we) match_q <= match_wd;
         if (mask_we)  mask_q  <= mask_wd;
         if (hit)         raw_q <= 1'b1;
         else if (clr_we) raw_q <= 1'b0;
      end
   end

   assign irq_o = raw_q & mask_q;

endmodule

// File: rtl/secs_rtc_bus.sv
`timescale 1ns/1ps
module secs_rtc_bus
   import secs_rtc_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 32,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic [CNT_W-1:0]  match_q,
   input  logic [CNT_W-1:0]  ld_q,
   input  logic              mask_q,
   input  logic              raw_q,
   output wr_sel_t           wsel,
   output logic [DATA_W-1:0] bus_rdata
);

   localparam int IDX_W   = ADDR_W - 2;
   localparam int ID_BASE = (1 << IDX_W) - ID_WORDS;

   logic [IDX_W-1:0]  widx;
   logic [DATA_W-1:0] rd_next;
   logic [7:0]        id_rom [ID_WORDS];
   logic              unused_lowaddr;

   assign widx           = bus_addr[ADDR_W-1:2];
   assign unused_lowaddr = ^bus_addr[1:0];

   for (genvar g = 0; g < ID_WORDS; g++) begin : g_id
      assign id_rom[g] = id_byte(g);
   end

   always_comb begin
      wsel       = '0;
      wsel.load  = bus_wr && (widx == IDX_W'(WIDX_LOAD));
      wsel.match = bus_wr && (widx == IDX_W'(WIDX_MATCH));
      wsel.mask  = bus_wr && (widx == IDX_W'(WIDX_MASK));
      wsel.clr   = bus_wr && (widx == IDX_W'(WIDX_CLR));
   end

   always_comb begin
      rd_next = '0;
      if (int'(widx) >= ID_BASE) begin
         rd_next[7:0] = id_rom[int'(widx) - ID_BASE];
      end else begin
         case (int'(widx))
            WIDX_COUNT: rd_next = DATA_W'(cnt_q);
            WIDX_MATCH: rd_next = DATA_W'(match_q);
            WIDX_LOAD:  rd_next = DATA_W'(ld_q);
            WIDX_CTRL:  rd_next = DATA_W'(1);
            WIDX_MASK:  rd_next = DATA_W'(mask_q);
            WIDX_RAW:   rd_next = DATA_W'(raw_q);
            WIDX_MSKD:  rd_next = DATA_W'(raw_q & mask_q);
            default:    rd_next = '0;
         endcase
      end
   end

   if (RDATA_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (rst) bus_rdata <= '0;
         else     bus_rdata <= rd_next;
      end
   end else begin : g_rd_comb
      logic unused_clkrst;
      assign unused_clkrst = clk ^ rst;
      assign bus_rdata     = rd_next;
   end

endmodule

// File: rtl/secs_rtc.sv
`timescale 1ns/1ps
module secs_rtc
   import secs_rtc_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 32,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);

   if (ADDR_W < 6) begin : g_bad_addr
      $error("secs_rtc: ADDR_W too small for register map and ID block");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("secs_rtc: CNT_W must lie in 2..DATA_W");
   end

   wr_sel_t          wsel;
   logic [CNT_W-1:0] cnt_q, cnt_inc, ld_q, match_q;
   logic             mask_q, raw_q;
   logic             ld_we, clr_we;
   logic [CNT_W-1:0] wd_cnt;

   assign ld_we  = wsel.load;
   assign clr_we = wsel.clr;
   assign wd_cnt = bus_wdata[CNT_W-1:0];

   if (DATA_W > CNT_W) begin : g_wd_wide
      logic unused_wd_hi;
      assign unused_wd_hi = ^bus_wdata[DATA_W-1:CNT_W];
   end

   secs_rtc_bus #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RDATA_REG(RDATA_REG)
   ) u_bus (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .cnt_q(cnt_q), .match_q(match_q), .ld_q(ld_q),
      .mask_q(mask_q), .raw_q(raw_q), .wsel(wsel), .bus_rdata(bus_rdata)
   );

   secs_rtc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .tick_i(tick_i), .ld_we(ld_we), .ld_val(wd_cnt),
      .cnt_q(cnt_q), .cnt_inc(cnt_inc), .ld_q(ld_q)
   );

   secs_rtc_alarm #(.CNT_W(CNT_W)) u_alarm (
      .clk(clk), .rst(rst), .tick_i(tick_i), .ld_we(ld_we), .cnt_inc(cnt_inc),
      .match_we(wsel.match), .match_wd(wd_cnt),
      .mask_we(wsel.mask), .mask_wd(bus_wdata[0]),
      .clr_we(clr_we), .match_q(match_q), .mask_q(mask_q), .raw_q(raw_q),
      .irq_o(irq_o)
   );

endmodule

// File: rtl/secs_rtc_chk.sv
`timescale 1ns/1ps
module secs_rtc_chk #(
   parameter int CNT_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              tick_i,
   input logic              ld_we,
   input logic              clr_we,
   input logic [DATA_W-1:0] wdata,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  match,
   input logic              mask,
   input logic              raw,
   input logic              irq
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   p_reset_r1: assert property (@(posedge clk)
      rst |=> (cnt == '0 && match == '0 && !mask && !raw));

   p_step_r2: assert property (@(posedge clk) disable iff (rst)
      (tick_i && !ld_we) |=> cnt == $past(cnt) + ONE);

   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (!tick_i && !ld_we) |=> $stable(cnt));

   p_load_r3: assert property (@(posedge clk) disable iff (rst)
      ld_we |=> cnt == $past(wdata[CNT_W-1:0]));

   p_set_r5: assert property (@(posedge clk) disable iff (rst)
      (tick_i && !ld_we && (cnt + ONE) == match) |=> raw);

   p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      (raw && !clr_we) |=> raw);

   p_clear_r6: assert property (@(posedge clk) disable iff (rst)
      (clr_we && !(tick_i && !ld_we && (cnt + ONE) == match)) |=> !raw);

   p_irq_mask_r7: assert property (@(posedge clk) disable iff (rst)
      (!mask || !raw) |-> !irq);

endmodule

bind secs_rtc secs_rtc_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst(rst), .tick_i(tick_i), .ld_we(ld_we), .clr_we(clr_we),
   .wdata(bus_wdata), .cnt(cnt_q), .match(match_q), .mask(mask_q),
   .raw(raw_q), .irq(irq_o)
);

// File: tb/tb_secs_rtc.sv
`timescale 1ns/1ps
module tb_secs_rtc;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tick_i = 1'b0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   secs_rtc dut (
      .clk(clk), .rst(rst), .tick_i(tick_i), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o)
   );

   // op: 0 read-compare, 1 write, 2 tick
   typedef struct packed {
      logic [1:0]  op;
      logic [11:0] a;
      logic [31:0] d;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 40;
   localparam vec_t TBL [NV] = '{
      '{2'd0, 12'h000, 32'h0,        4'd1},  // R1
      '{2'd0, 12'h004, 32'h0,        4'd1},
      '{2'd0, 12'h010, 32'h0,        4'd1},
      '{2'd0, 12'h014, 32'h0,        4'd1},
      '{2'd0, 12'h00C, 32'h1,        4'd8},  // R8
      '{2'd1, 12'h00C, 32'h0,        4'd8},
      '{2'd0, 12'h00C, 32'h1,        4'd8},
      '{2'd1, 12'h008, 32'h100,      4'd3},  // R3
      '{2'd0, 12'h000, 32'h100,      4'd3},
      '{2'd0, 12'h008, 32'h100,      4'd3},
      '{2'd2, 12'h000, 32'h0,        4'd2},  // R2
      '{2'd0, 12'h000, 32'h101,      4'd2},
      '{2'd1, 12'h004, 32'h103,      4'd4},  // R4
      '{2'd0, 12'h004, 32'h103,      4'd4},
      '{2'd2, 12'h000, 32'h0,        4'd5},  // R5: count 0x102, no hit
      '{2'd0, 12'h014, 32'h0,        4'd5},
      '{2'd2, 12'h000, 32'h0,        4'd5},  // count 0x103 = match
      '{2'd0, 12'h014, 32'h1,        4'd5},
      '{2'd0, 12'h018, 32'h0,        4'd7},  // R7 masked off
      '{2'd1, 12'h010, 32'hFFFFFFFF, 4'd7},
      '{2'd0, 12'h010, 32'h1,        4'd7},
      '{2'd0, 12'h018, 32'h1,        4'd7},
      '{2'd1, 12'h01C, 32'h0,        4'd6},  // R6 data 0 still clears
      '{2'd0, 12'h014, 32'h0,        4'd6},
      '{2'd0, 12'h018, 32'h0,        4'd6},
      '{2'd1, 12'h000, 32'hDEAD,     4'd10}, // R10
      '{2'd0, 12'h000, 32'h103,      4'd10},
      '{2'd0, 12'h020, 32'h0,        4'd10},
      '{2'd0, 12'h100, 32'h0,        4'd10},
      '{2'd1, 12'h020, 32'h5,        4'd10},
      '{2'd0, 12'h000, 32'h103,      4'd10},
      '{2'd0, 12'hFDC, 32'h0,        4'd10},
      '{2'd0, 12'hFE0, 32'h31,       4'd9},  // R9
      '{2'd0, 12'hFE4, 32'h10,       4'd9},
      '{2'd0, 12'hFE8, 32'h14,       4'd9},
      '{2'd0, 12'hFEC, 32'h00,       4'd9},
      '{2'd0, 12'hFF0, 32'h0D,       4'd9},
      '{2'd0, 12'hFF4, 32'hF0,       4'd9},
      '{2'd0, 12'hFF8, 32'h05,       4'd9},
      '{2'd0, 12'hFFC, 32'hB1,       4'd9}
   };

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic tk);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick_i = tk;
      @(negedge clk);
      bus_wr = 1'b0; tick_i = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input string rq, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0;
      #1;
      check(rq, bus_rdata, exp);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d", TBL[i].rq);
         case (TBL[i].op)
            2'd0: rd(TBL[i].a, tag, TBL[i].d);
            2'd1: wr(TBL[i].a, TBL[i].d, 1'b0);
            default: tick();
         endcase
      end

      // R2 idle cycles leave count unchanged
      repeat (5) @(negedge clk);
      rd(12'h000, "R2", 32'h103);

      // R5 wrap: match below count fires after rollover; mask still 1
      wr(12'h004, 32'h1, 1'b0);
      wr(12'h008, 32'hFFFFFFFE, 1'b0);
      tick();
      rd(12'h000, "R2", 32'hFFFFFFFF);
      tick();
      rd(12'h000, "R2", 32'h0);
      rd(12'h014, "R5", 32'h0);
      tick();
      rd(12'h014, "R5", 32'h1);
      check("R7", {31'b0, irq_o}, 32'h1);

      // R7 mask gates irq
      wr(12'h010, 32'h0, 1'b0);
      #1 check("R7", {31'b0, irq_o}, 32'h0);
      rd(12'h014, "R7", 32'h1);
      wr(12'h010, 32'h1, 1'b0);
      #1 check("R7", {31'b0, irq_o}, 32'h1);

      // R3 load wins over tick in same cycle, and does not raise alarm
      wr(12'h01C, 32'h0, 1'b0);
      wr(12'h008, 32'h0, 1'b1);
      rd(12'h000, "R3", 32'h0);
      rd(12'h014, "R3", 32'h0);

      // R6 set wins over simultaneous clear
      wr(12'h004, 32'hA, 1'b0);
      wr(12'h008, 32'h9, 1'b0);
      wr(12'h01C, 32'h1, 1'b1);
      rd(12'h014, "R6", 32'h1);
      rd(12'h000, "R6", 32'hA);

      // R1 reset mid-run
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R1", {31'b0, irq_o}, 32'h0);
      rd(12'h000, "R1", 32'h0);
      rd(12'h004, "R1", 32'h0);
      rd(12'h008, "R1", 32'h0);
      rd(12'h010, "R1", 32'h0);
      rd(12'h014, "R1", 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule